// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit resolves control transfers for a 32-bit processor whose pipeline always executes one instruction after a branch (the delay slot). For each accepted instruction it takes the program counter, the instruction word and the two source operand values, which arrive already read from the register file. It reports whether the instruction transfers control and to which address. It also reports whether a return address must be written and whether the following slot instruction must be squashed.

A taken transfer is not applied at once. The unit holds the target in a small redirect register. The next accepted instruction is the delay slot, and it issues with a redirect indication that carries the held target. Fetch then continues from that address. The register file, fetch and memory are outside this unit.

The instruction input is a valid/ready stream. The unit never applies back-pressure: `in_ready` is always high, so any cycle with `in_valid` high is an accepted instruction. Cycles with `in_valid` low are bubbles. Bubbles leave a pending redirect waiting for the next accepted instruction. All result outputs are plain combinational signals that are meaningful only in the cycle an instruction is accepted.

Top module: `ctl_redirect_unit`

## Requirements
- R1: For opcodes 1, 4, 5, 6 and 7 (opcode in bits 31:26), `target_pc` equals pc + 4 + (bits 15:0 sign-extended and shifted left by 2).
- R2: For opcodes 2 (jump) and 3 (jump-and-link), `taken` is high and `target_pc` is {pc[31:28], bits 25:0, 2'b00}.
- R3: Opcode 4 is taken when `rs_val` equals `rt_val`. Opcode 5 is taken when they differ.
- R4: Opcode 6 is taken when `rs_val` is negative or zero. Opcode 7 is taken only when `rs_val` is positive and nonzero.
- R5: Opcode 1 picks its test from bits 20:16. Codes 0, 2, 16 and 18 are taken when `rs_val` is negative. Codes 1, 3, 17 and 19 are taken when `rs_val` is not negative. Any other code yields no taken, link or annul output.
- R6: Opcode 3, and opcode 1 with codes 16 to 19, raise `link_we` whether taken or not, with `link_idx` = 31 and `link_value` = pc + 8.
- R7: Opcode 1 with codes 2, 3, 18 or 19 raises `annul` when not taken. `annul` is never high together with `taken`.
- R8: After an accepted taken instruction, the next accepted instruction has `redirect_valid` high and `redirect_pc` equal to that target. Bubbles in between do not consume the redirect. An accepted instruction that has no pending redirect has `redirect_valid` low.
- R9: Reset discards any pending redirect.
- R10: Any other opcode, and any cycle with `in_valid` low, gives `taken`, `link_we`, `annul` and `redirect_valid` all low.
- R11: `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_ready | output | 1 | Always high; the unit never stalls |
| pc | input | 32 | Address of the instruction |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| taken | output | 1 | Control transfer will occur |
| target_pc | output | 32 | Transfer destination |
| link_we | output | 1 | Write return address |
| link_idx | output | 5 | Return address register index (31) |
| link_value | output | 32 | Return address, pc + 8 |
| annul | output | 1 | Squash the following slot instruction |
| redirect_valid | output | 1 | This instruction is a delay slot; fetch moves to redirect_pc next |
| redirect_pc | output | 32 | Held target from the preceding taken transfer |

## Verification
The assertions rely on `pc`, `instr` and the operand values being stable for the whole cycle in which `in_valid` is high. They also rely on a redirect being checked only on the next accepted instruction and not on bubbles. The stimulus drives every input on the falling edge and holds it until the next falling edge. It inserts deliberate bubbles between a taken branch and its slot, and it never issues a second branch inside a delay slot, a case whose outcome the requirements leave open.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int OP_W = 6;
  localparam int SEL_W = 5;

  localparam logic [OP_W-1:0] OPC_SIGNTEST = 6'd1;
  localparam logic [OP_W-1:0] OPC_JUMP     = 6'd2;
  localparam logic [OP_W-1:0] OPC_JLINK    = 6'd3;
  localparam logic [OP_W-1:0] OPC_EQ       = 6'd4;
  localparam logic [OP_W-1:0] OPC_NE       = 6'd5;
  localparam logic [OP_W-1:0] OPC_LEZ      = 6'd6;
  localparam logic [OP_W-1:0] OPC_GTZ      = 6'd7;

  typedef enum logic [2:0] {
    K_NONE, K_JUMP, K_EQ, K_NE, K_LEZ, K_GTZ, K_SIGN
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  link;
    logic  likely;
    logic  want_neg;
  } dec_t;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [SEL_W-1:0] sel,
  output dec_t             dec
);
  always_comb begin
    dec = '{kind: K_NONE, link: 1'b0, likely: 1'b0, want_neg: 1'b0};
    unique case (opcode)
      OPC_JUMP:  dec.kind = K_JUMP;
      OPC_JLINK: begin
        dec.kind = K_JUMP;
        dec.link = 1'b1;
      end
      OPC_EQ:  dec.kind = K_EQ;
      OPC_NE:  dec.kind = K_NE;
      OPC_LEZ: dec.kind = K_LEZ;
      OPC_GTZ: dec.kind = K_GTZ;
      OPC_SIGNTEST: begin
        // bits: [4]=link, [1]=likely, [0]=test non-negative; others must be 0
        if (sel[3:2] == 2'b00) begin
          dec.kind     = K_SIGN;
          dec.link     = sel[4];
          dec.likely   = sel[1];
          dec.want_neg = ~sel[0];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
#(
  parameter int W = 32
) (
  input  dec_t         dec,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  logic neg, zero, same;

  assign neg  = a[W-1];
  assign zero = (a == '0);
  assign same = (a == b);

  always_comb begin
    unique case (dec.kind)
      K_JUMP:  hit = 1'b1;
      K_EQ:    hit = same;
      K_NE:    hit = ~same;
      K_LEZ:   hit = neg | zero;
      K_GTZ:   hit = ~neg & ~zero;
      K_SIGN:  hit = (neg == dec.want_neg);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brx_target.sv
module brx_target
  import brx_pkg::*;
#(
  parameter int W        = 32,
  parameter int OFF_W    = 16,
  parameter int REGION_W = 4
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] instr,
  input  kind_e        kind,
  output logic [W-1:0] target,
  output logic [W-1:0] ret_addr
);
  localparam int IDX_W  = W - REGION_W - 2;
  localparam int EXT_W  = W - OFF_W - 2;
  localparam int INSN_B = 4;

  logic [W-1:0] rel_off, rel_tgt, abs_tgt, seq_pc;

  assign seq_pc   = pc + W'(INSN_B);
  assign ret_addr = pc + W'(2 * INSN_B);
  assign rel_off  = {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0], 2'b00};
  assign rel_tgt  = seq_pc + rel_off;
  assign abs_tgt  = {pc[W-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
  assign target   = (kind == K_JUMP) ? abs_tgt : rel_tgt;
endmodule

// File: rtl/brx_redirect.sv
module brx_redirect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         take,
  input  logic [W-1:0] dest,
  output logic         fire,
  output logic [W-1:0] fire_pc
);
  logic         pend_q;
  logic [W-1:0] dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dest_q <= '0;
    end else if (accept) begin
      pend_q <= take;
      if (take) dest_q <= dest;
    end
  end

  assign fire    = pend_q & accept;
  assign fire_pc = dest_q;
endmodule

// File: rtl/ctl_redirect_unit.sv
module ctl_redirect_unit
  import brx_pkg::*;
#(
  parameter int W        = 32,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     pc,
  input  logic [W-1:0]     instr,
  input  logic [W-1:0]     rs_val,
  input  logic [W-1:0]     rt_val,
  output logic             taken,
  output logic [W-1:0]     target_pc,
  output logic             link_we,
  output logic [REG_W-1:0] link_idx,
  output logic [W-1:0]     link_value,
  output logic             annul,
  output logic             redirect_valid,
  output logic [W-1:0]     redirect_pc
);
  localparam int OP_LSB  = W - OP_W;
  localparam int SEL_LSB = 16;

  dec_t dec;
  logic hit;

  brx_decode u_dec (
    .opcode (instr[W-1:OP_LSB]),
    .sel    (instr[SEL_LSB +: SEL_W]),
    .dec    (dec)
  );

  brx_cond #(.W(W)) u_cond (
    .dec (dec),
    .a   (rs_val),
    .b   (rt_val),
    .hit (hit)
  );

  brx_target #(.W(W)) u_tgt (
    .pc       (pc),
    .instr    (instr),
    .kind     (dec.kind),
    .target   (target_pc),
    .ret_addr (link_value)
  );

  assign in_ready = 1'b1;
  assign taken    = in_valid & hit;
  assign link_we  = in_valid & dec.link;
  assign link_idx = REG_W'(LINK_REG);
  assign annul    = in_valid & dec.likely & ~hit;

  brx_redirect #(.W(W)) u_rdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (in_valid),
    .take    (taken),
    .dest    (target_pc),
    .fire    (redirect_valid),
    .fire_pc (redirect_pc)
  );
endmodule

// File: rtl/brx_checker.sv
module brx_checker #(
  parameter int W     = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     pc,
  input logic             taken,
  input logic [W-1:0]     target_pc,
  input logic             link_we,
  input logic [REG_W-1:0] link_idx,
  input logic [W-1:0]     link_value,
  input logic             annul,
  input logic             redirect_valid,
  input logic [W-1:0]     redirect_pc
);
  // R8
  slot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && taken) |=> (in_valid |-> (redirect_valid && redirect_pc == $past(target_pc))));

  // R7
  annul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    annul |-> !taken);

  // R10
  bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!taken && !link_we && !annul && !redirect_valid));

  // R6
  link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx == REG_W'(31) && link_value == pc + W'(8)));

  // R11
  never_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

bind ctl_redirect_unit brx_checker #(.W(W), .REG_W(REG_W)) i_brx_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .pc             (pc),
  .taken          (taken),
  .target_pc      (target_pc),
  .link_we        (link_we),
  .link_idx       (link_idx),
  .link_value     (link_value),
  .annul          (annul),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc)
);

// File: tb/test_ctl_redirect_unit.sv
module test_ctl_redirect_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] pc = '0, instr = '0, rs_val = '0, rt_val = '0;
  logic        taken, link_we, annul, redirect_valid;
  logic [31:0] target_pc, link_value, redirect_pc;
  logic [4:0]  link_idx;

  always #4 clk = ~clk;

  ctl_redirect_unit i_ctl_redirect_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .taken(taken), .target_pc(target_pc), .link_we(link_we),
    .link_idx(link_idx), .link_value(link_value), .annul(annul),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  typedef struct {
    logic        tk;
    logic [31:0] tgt;
    logic        lw;
    logic [31:0] lv;
    logic        an;
    logic        rv;
    logic [31:0] rp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, failures = 0;
  logic        m_pend = 1'b0;
  logic [31:0] m_tgt = '0;
  bit          done = 0;

  function automatic logic [31:0] mk_i(int op, int sel, logic [15:0] imm);
    return {op[5:0], 5'd3, sel[4:0], imm};
  endfunction

  function automatic logic [31:0] mk_j(int op, logic [25:0] idx);
    return {op[5:0], idx};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Independent reference of the requirement table
  task automatic issue(logic [31:0] p, logic [31:0] ins, logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    int   op, sel;
    @(negedge clk);
    pc = p; instr = ins; rs_val = a; rt_val = b; in_valid = 1'b1;
    op  = int'(ins[31:26]);
    sel = int'(ins[20:16]);
    e.tk = 0; e.lw = 0; e.an = 0; e.tag = tag;
    e.tgt = p + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    e.lv  = p + 32'd8;
    case (op)
      2, 3: begin
        e.tk  = 1;
        e.tgt = {p[31:28], ins[25:0], 2'b00};
        e.lw  = (op == 3);
      end
      4: e.tk = (a == b);
      5: e.tk = (a != b);
      6: e.tk = ($signed(a) <= 0);
      7: e.tk = ($signed(a) > 0);
      1: begin
        if (sel inside {0, 2, 16, 18}) e.tk = ($signed(a) < 0);
        if (sel inside {1, 3, 17, 19}) e.tk = ($signed(a) >= 0);
        if (sel inside {16, 17, 18, 19}) e.lw = 1;
        if (sel inside {2, 3, 18, 19}) e.an = !e.tk;
      end
      default: ;
    endcase
    e.rv = m_pend;
    e.rp = m_tgt;
    m_pend = e.tk;
    if (e.tk) m_tgt = e.tgt;
    sb.push_back(e);
  endtask

  task automatic bubble(string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    instr = mk_i(4, 3, 16'h0001);
    e = '{tk: 0, tgt: 0, lw: 0, lv: 0, an: 0, rv: 0, rp: 0, tag: tag};
    sb.push_back(e);
  endtask

  // monitor: compares 2 ns after the falling edge the item was driven on
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk});
        if (e.tk) check(e.tag, "target_pc", target_pc, e.tgt);
        check(e.tag, "link_we", {31'd0, link_we}, {31'd0, e.lw});
        if (e.lw) begin
          check(e.tag, "link_value", link_value, e.lv);
          check(e.tag, "link_idx", {27'd0, link_idx}, 32'd31);
        end
        check(e.tag, "annul", {31'd0, annul}, {31'd0, e.an});
        check(e.tag, "redirect_valid", {31'd0, redirect_valid}, {31'd0, e.rv});
        if (e.rv) check(e.tag, "redirect_pc", redirect_pc, e.rp);
        check("R11", "in_ready", {31'd0, in_ready}, 32'd1);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 R10: reset state, non-branch opcode
    issue(32'h0000_0100, 32'h0000_0000, 32'd1, 32'd1, "R9");
    issue(32'h0000_0104, mk_i(8, 0, 16'h0004), 32'd0, 32'd0, "R10");
    issue(32'h0000_0108, mk_i(35, 0, 16'h0004), 32'd0, 32'd0, "R10");
    // R3 R1: equal branch taken, forward offset, then slot
    issue(32'h0000_1000, mk_i(4, 3, 16'h0003), 32'd7, 32'd7, "R3");
    issue(32'h0000_1004, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_1010, mk_i(5, 3, 16'h0003), 32'd7, 32'd7, "R3");
    issue(32'h0000_1014, 32'h0, 32'd0, 32'd0, "R8");
    // R1: backward offset, with bubbles before the slot
    issue(32'h0000_2000, mk_i(5, 3, 16'hFFFE), 32'd1, 32'd2, "R1");
    bubble("R10");
    bubble("R8");
    issue(32'h0000_2004, 32'h0, 32'd0, 32'd0, "R8");
    // R4
    issue(32'h0000_3000, mk_i(6, 0, 16'h0010), 32'd0, 32'd0, "R4");
    issue(32'h0000_3004, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_3100, mk_i(6, 0, 16'h0010), 32'd5, 32'd0, "R4");
    issue(32'h0000_3200, mk_i(6, 0, 16'h0010), 32'h8000_0000, 32'd0, "R4");
    issue(32'h0000_3204, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_3300, mk_i(7, 0, 16'h0010), 32'd0, 32'd0, "R4");
    issue(32'h0000_3400, mk_i(7, 0, 16'h0010), 32'd1, 32'd0, "R4");
    issue(32'h0000_3404, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_3500, mk_i(7, 0, 16'h0010), 32'hFFFF_FFFF, 32'd0, "R4");
    // R5 R6 R7: sign-test group
    issue(32'h0000_4000, mk_i(1, 0, 16'h0020), 32'hFFFF_FFF0, 32'd0, "R5");
    issue(32'h0000_4004, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_4100, mk_i(1, 1, 16'h0020), 32'd0, 32'd0, "R5");
    issue(32'h0000_4104, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_4200, mk_i(1, 16, 16'h0020), 32'd9, 32'd0, "R6");
    issue(32'h0000_4300, mk_i(1, 17, 16'h0020), 32'd9, 32'd0, "R6");
    issue(32'h0000_4304, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_4400, mk_i(1, 2, 16'h0020), 32'd9, 32'd0, "R7");
    issue(32'h0000_4500, mk_i(1, 3, 16'h0020), 32'd9, 32'd0, "R7");
    issue(32'h0000_4504, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h0000_4600, mk_i(1, 18, 16'h0020), 32'd9, 32'd0, "R7");
    issue(32'h0000_4700, mk_i(1, 19, 16'h0020), 32'h8000_0001, 32'd0, "R7");
    issue(32'h0000_4800, mk_i(1, 5, 16'h0020), 32'h8000_0001, 32'd0, "R5");
    issue(32'h0000_4900, mk_i(1, 24, 16'h0020), 32'd1, 32'd0, "R5");
    // R2: region-relative jumps
    issue(32'hA000_0100, mk_j(2, 26'h0123456), 32'd0, 32'd0, "R2");
    issue(32'hA000_0104, 32'h0, 32'd0, 32'd0, "R8");
    issue(32'h7FFF_FFF8, mk_j(3, 26'h3FFFFFF), 32'd0, 32'd0, "R6");
    issue(32'h7FFF_FFFC, 32'h0, 32'd0, 32'd0, "R8");
    // R9: reset drops a pending redirect
    issue(32'h0000_5000, mk_j(2, 26'h0000040), 32'd0, 32'd0, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    m_pend = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(32'h0000_5004, 32'h0, 32'd0, 32'd0, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule